// File: doc/BRIEF.md
# Interrupt Mask and Block-End Pending Unit

This unit sits beside a byte-level J1850 decoder that moves data over receive and transmit DMA. It keeps an 8-bit interrupt enable register, one pending flag per DMA direction that records a finished block, and one registered interrupt request line. Each raw source flag of the decoder is gated by its own enable bit. The two block-end flags reach the request line through the enable bits of the receive-data-full and transmit-ready sources.

When a block completes, its flag is set and the enable bit of that DMA direction is cleared in the same cycle, so no further DMA requests are raised until software turns the enable bit back on. Software can clear a flag only by writing zero to it. The whole state is cleared after the disable control has stayed high for a minimum run of consecutive cycles. A shorter run changes nothing.

Top module: `jirq_mask_unit`

## Requirements
- R1: After reset the enable register reads 00h, both pending flags read 0 and `irq_o` is 0.
- R2: A write with `reg_sel_i`=0 loads the enable register, which reads back on `reg_rdata_o` in the next cycle. The bits, from 7 down to 0, enable: error, transmit-ready, receive-data-full, transmit-lost-arbitration, receive-DMA, end-of-data, end-of-frame, transmit-DMA.
- R3: `irq_o` is 1 in the cycle after a cycle in which some `src_i[k]` and enable bit k are both 1. A raw source whose enable bit is 0 never raises the request.
- R4: A `rx_blk_done_i` pulse sets the receive pending flag (bit 1 of the pending view, `reg_sel_i`=1) and clears enable bit 3.
- R5: A `tx_blk_done_i` pulse sets the transmit pending flag (bit 0 of the pending view) and clears enable bit 0.
- R6: The receive pending flag raises `irq_o` one cycle later only while enable bit 5 is 1. The transmit pending flag does the same only while enable bit 6 is 1.
- R7: A write with `reg_sel_i`=1 clears each pending flag whose data bit (1 for receive, 0 for transmit) is 0. A data bit of 1 leaves its flag unchanged, and a clear flag is never set by a write.
- R8: When a block-complete pulse and a write of zero to the same flag fall in one cycle, the flag ends up set.
- R9: When `dis_i` has been high for 6 consecutive sampled edges, the enable register and both flags are 0 after the sixth edge and stay 0 while it remains high. A run of fewer than 6 clears nothing, and the count starts again after `dis_i` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_i | input | 1 | Disable control; a long enough run clears the state |
| rx_blk_done_i | input | 1 | Receive DMA block-complete pulse |
| tx_blk_done_i | input | 1 | Transmit DMA block-complete pulse |
| src_i | input | 8 | Raw interrupt source flags, in the same bit order as the enable register |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the enable register, 1 selects the pending view |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (pending view: bit 1 receive, bit 0 transmit) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The main function is driven with single raw sources against enable patterns that have the matching bit set and cleared. This separates correct gating from a request line that simply ORs the raw flags. Block-complete pulses are given with the companion enable bits 5 and 6 toggled, which shows whether each flag is routed to the correct enable bit. They are also given together with writes to the pending view, which settles both the write-one case and the set-versus-clear race. Disable runs of five and of six cycles show where the clearing threshold lies. A long pseudo-random stretch then mixes every input and compares the outputs cycle by cycle with a behavioural model.

// File: rtl/jirq_pkg.sv
package jirq_pkg;
  localparam int unsigned MASK_W = 8;

  // enable bit positions, decoded by the request logic
  localparam int unsigned B_TXRDY = 6;
  localparam int unsigned B_RXFULL = 5;
  localparam int unsigned B_RXDMA = 3;
  localparam int unsigned B_TXDMA = 0;

  // pending-view lanes
  localparam int unsigned LN_TX = 0;
  localparam int unsigned LN_RX = 1;
  localparam int unsigned LANES = 2;

  function automatic logic req_any(input logic [MASK_W-1:0] en,
                                   input logic [MASK_W-1:0] src,
                                   input logic rx_p, input logic tx_p);
    logic r;
    r = |(en & src);
    r = r | (rx_p & en[B_RXFULL]);
    r = r | (tx_p & en[B_TXRDY]);
    return r;
  endfunction

  function automatic logic [MASK_W-1:0] en_next(input logic [MASK_W-1:0] cur,
                                                input logic wr,
                                                input logic [MASK_W-1:0] wd,
                                                input logic rx_done,
                                                input logic tx_done);
    logic [MASK_W-1:0] n;
    n = wr ? wd : cur;
    if (rx_done) n[B_RXDMA] = 1'b0;
    if (tx_done) n[B_TXDMA] = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/jirq_hold_timer.sv
module jirq_hold_timer #(
  parameter int unsigned HOLD = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_i,
  output logic clr_o
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_q;
  logic          at_limit;

  assign at_limit = (run_q >= LAST);
  assign clr_o    = dis_i && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (!dis_i) run_q <= '0;
    else if (!at_limit) run_q <= run_q + 1'b1;
  end

  AST_CLR_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> $past(dis_i)); // R9
endmodule

// File: rtl/jirq_pend_flag.sv
module jirq_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  input  logic wr0_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (clr_i)  q <= 1'b0;
    else if (set_i)  q <= 1'b1;
    else if (wr0_i)  q <= 1'b0;
  end

  assign q_o = q;

  AST_SET_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q); // R8
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!q && !set_i) |=> !q); // R7
endmodule

// File: rtl/jirq_en_reg.sv
module jirq_en_reg
  import jirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] wdata_i,
  input  logic              rx_done_i,
  input  logic              tx_done_i,
  output logic [MASK_W-1:0] en_o
);
  logic [MASK_W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (clr_i) en_q <= '0;
    else            en_q <= en_next(en_q, wr_i, wdata_i, rx_done_i, tx_done_i);
  end

  assign en_o = en_q;

  AST_RXDMA_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> !en_q[B_RXDMA]); // R4
  AST_TXDMA_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_i |=> !en_q[B_TXDMA]); // R5
endmodule

// File: rtl/jirq_mask_unit.sv
module jirq_mask_unit
  import jirq_pkg::*;
#(
  parameter int unsigned HOLD = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dis_i,
  input  logic              rx_blk_done_i,
  input  logic              tx_blk_done_i,
  input  logic [MASK_W-1:0] src_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [MASK_W-1:0] reg_wdata_i,
  output logic [MASK_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic              hold_clr;
  logic [MASK_W-1:0] en;
  logic [LANES-1:0]  pend;
  logic [LANES-1:0]  lane_set;
  logic [LANES-1:0]  lane_wr0;
  logic              en_wr;
  logic              req_now;
  logic              irq_q;

  jirq_hold_timer #(.HOLD(HOLD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .dis_i (dis_i),
    .clr_o (hold_clr)
  );

  assign en_wr = reg_wr_i && !reg_sel_i;

  jirq_en_reg u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (hold_clr),
    .wr_i      (en_wr),
    .wdata_i   (reg_wdata_i),
    .rx_done_i (rx_blk_done_i),
    .tx_done_i (tx_blk_done_i),
    .en_o      (en)
  );

  assign lane_set[LN_RX] = rx_blk_done_i;
  assign lane_set[LN_TX] = tx_blk_done_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr0[g] = reg_wr_i && reg_sel_i && !reg_wdata_i[g];
    jirq_pend_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (hold_clr),
      .set_i (lane_set[g]),
      .wr0_i (lane_wr0[g]),
      .q_o   (pend[g])
    );
  end

  assign req_now = req_any(en, src_i, pend[LN_RX], pend[LN_TX]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= req_now;
  end

  assign irq_o       = irq_q;
  assign reg_rdata_o = reg_sel_i ? {{(MASK_W-LANES){1'b0}}, pend} : en;

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq_o); // R3
  AST_RX_NEEDS_RXFULL: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0 && !pend[LN_TX] && !en[B_RXFULL]) |=> !irq_o); // R6
  AST_HOLD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |=> (en == '0 && pend == '0)); // R9
endmodule

// File: tb/jirq_mask_unit_tb.sv
module jirq_mask_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dis = 1'b0, rxd = 1'b0, txd = 1'b0, wr = 1'b0, sel = 1'b0;
  logic [7:0] src = 8'h00, wd = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  jirq_mask_unit u_dut (
    .clk(clk), .rst_n(rst_n), .dis_i(dis), .rx_blk_done_i(rxd),
    .tx_blk_done_i(txd), .src_i(src), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit [7:0] m_en;
  bit       m_rx, m_tx, m_irq;
  int       m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_rx = 0; m_tx = 0; m_irq = 0; m_run = 0;
    end else begin
      bit req;
      req = 0;
      for (int k = 0; k < 8; k++) if (m_en[k] && src[k]) req = 1;
      if (m_rx && m_en[5]) req = 1;
      if (m_tx && m_en[6]) req = 1;
      m_irq = req;
      m_run = dis ? m_run + 1 : 0;
      if (m_run >= 6) begin
        m_en = 0; m_rx = 0; m_tx = 0;
      end else begin
        if (wr && !sel) m_en = wd;
        if (rxd) m_en[3] = 0;
        if (txd) m_en[0] = 0;
        if (rxd) m_rx = 1; else if (wr && sel && wd[1] == 0) m_rx = 0;
        if (txd) m_tx = 1; else if (wr && sel && wd[0] == 0) m_tx = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      exp_rd = sel ? {6'b0, m_rx, m_tx} : m_en;
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R3 model irq: actual %0b expected %0b at %0t", irq, m_irq, $time);
      end
      checks++;
      if (rdata !== exp_rd) begin
        fails++;
        $display("FAIL R2 model rdata: actual %02h expected %02h at %0t", rdata, exp_rd, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic peek(input logic s, output logic [7:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    peek(1'b0, v); chk("R1 enable", v, 8'h00);
    peek(1'b1, v); chk("R1 pending", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    // R2 enable write
    sel = 0; wr = 1; wd = 8'hA5; cyc(); wr = 0;
    chk("R2 readback", rdata, 8'hA5);
    // R3 gated source
    src = 8'h80; cyc(); chk("R3 enabled source", {7'b0, irq}, 8'h01);
    src = 8'h40; cyc(); chk("R3 masked source", {7'b0, irq}, 8'h00);
    src = 8'h00;
    // R4 receive block end
    wr = 1; wd = 8'hFF; cyc(); wr = 0;
    rxd = 1; cyc(); rxd = 0;
    chk("R4 enable bit3 cleared", rdata, 8'hF7);
    peek(1'b1, v); chk("R4 rx pending", v, 8'h02);
    sel = 0; cyc();
    chk("R6 rx pending via bit5", {7'b0, irq}, 8'h01);
    // R6 drop bit5
    wr = 1; wd = 8'hD7; cyc(); wr = 0; cyc();
    chk("R6 rx pending gated off", {7'b0, irq}, 8'h00);
    // R7 write one ignored, write zero clears
    sel = 1; wr = 1; wd = 8'hFF; cyc(); wr = 0;
    chk("R7 write one ignored", rdata, 8'h02);
    wr = 1; wd = 8'hFD; cyc(); wr = 0;
    chk("R7 write zero clears", rdata, 8'h00);
    // R5 transmit block end
    txd = 1; cyc(); txd = 0;
    chk("R5 tx pending", rdata, 8'h01);
    peek(1'b0, v); chk("R5 enable bit0 cleared", v, 8'hD6);
    cyc();
    chk("R6 tx pending via bit6", {7'b0, irq}, 8'h01);
    // R8 set beats simultaneous write zero
    sel = 1; wr = 1; wd = 8'h00; rxd = 1; cyc(); wr = 0; rxd = 0;
    chk("R8 rx set wins, tx cleared", rdata, 8'h02);
    // R9 short run
    dis = 1; cyc(5); dis = 0; cyc();
    peek(1'b0, v); chk("R9 short run keeps enable", v, 8'hD6);
    peek(1'b1, v); chk("R9 short run keeps pending", v, 8'h02);
    dis = 1; cyc(5);
    chk("R9 five-cycle run after restart keeps pending", rdata, 8'h02);
    cyc(1);
    chk("R9 sixth cycle clears pending", rdata, 8'h00);
    peek(1'b0, v); chk("R9 sixth cycle clears enable", v, 8'h00);
    wr = 1; wd = 8'hFF; cyc(); wr = 0;
    chk("R9 held disable keeps clear", rdata, 8'h00);
    dis = 0; cyc();
    // pseudo-random mix against the model
    begin
      int dis_left = 0;
      for (int n = 0; n < 4000; n++) begin
        src = 8'($urandom) & 8'($urandom);
        rxd = ($urandom_range(0, 15) == 0);
        txd = ($urandom_range(0, 15) == 0);
        wr  = ($urandom_range(0, 3) == 0);
        sel = $urandom_range(0, 1);
        wd  = 8'($urandom);
        if (dis_left > 0) begin
          dis = 1; dis_left--;
        end else if ($urandom_range(0, 39) == 0) begin
          dis = 1; dis_left = $urandom_range(0, 8);
        end else dis = 0;
        cyc();
      end
    end
    finish_run();
  end
endmodule